// File: doc/BRIEF.md
# Byte-wide DAC register interface

This block is the digital front end of a 12-bit voltage-output converter. A host writes it through an 8-bit data bus, a 2-bit address and active-low select and write strobes. Each byte goes into one of three places: a low holding register for code bits 7..0, a high holding register for code bits 11..8, or a 5-bit control register. A separate DAC register drives the converter. It takes the holding contents while a load condition is present and keeps its value otherwise, so the host can stage a full code and apply it in one step.

All strobes and pins are treated as asynchronous levels. Each passes through a two-flop synchronizer. A write is recognised on a synchronized low-to-high transition of the write strobe. The bus contents used are those seen in the last sample before the transition. Three effective settings leave the block: power-down, fast settling and a reference choice. Each merges a hardware pin with a software bit at a fixed priority.

Top module: `dac_byte_if`

## Requirements
- R1: After reset, code is 0, powerDown, fastSettle, refInternal and refHigh are 0 (with pdPinN high and speedPin low), and both holding registers and the control register are 0.
- R2: A write is recognised when wrN is sampled high at a clock edge k, wrN was sampled low at edge k-1 and selN was sampled low at edge k-1. It takes busAddr and busData as sampled at edge k-1 and updates the addressed register at edge k+2. Each rising transition causes exactly one write.
- R3: Address 2'b00 loads busData[7:0] into code bits 7..0. Address 2'b01 loads busData[3:0] into code bits 11..8, and busData[7:4] is ignored.
- R4: Address 2'b10 is reserved: a write there changes neither holding register, the control register nor any output.
- R5: Address 2'b11 loads the control register from busData[4:0]: bit 4 is reference bit B, bit 3 is reference bit A, bit 2 is the software load bit, bit 1 is the software power-down bit and bit 0 is the software fast bit.
- R6: At each clock edge where loadN was sampled low two edges earlier, or the software load bit is 1, the DAC register takes {high holding, low holding}, and code shows it after that edge. Otherwise code holds.
- R7: With loadN held low, every write to a holding register reaches code one edge after the holding register updates, with no separate load pulse.
- R8: powerDown is 1 when pdPinN (synchronized, two edges of latency) is low, and otherwise equals the software power-down bit.
- R9: fastSettle is 1 when speedPin (synchronized, two edges of latency) is high or the software fast bit is 1.
- R10: With reference bits {B,A}: 2'b01 gives refInternal=1, refHigh=0 (internal 1.024 V); 2'b10 gives refInternal=1, refHigh=1 (internal 2.048 V); 2'b00 and 2'b11 give refInternal=0, refHigh=0 (external).
- R11: Entering or leaving power-down, by pin or by bit, does not change code, so the code in place before power-down is still present after release.
- R12: A write strobe transition while selN is sampled high changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| busData | input | 8 | Host data byte |
| busAddr | input | 2 | Register select |
| selN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe, data taken on its rising edge |
| loadN | input | 1 | Active-low load level for the DAC register |
| pdPinN | input | 1 | Active-low hardware power-down pin |
| speedPin | input | 1 | Hardware fast-settle pin, active high |
| code | output | 12 | Code presented to the converter |
| powerDown | output | 1 | Effective power-down |
| fastSettle | output | 1 | Effective fast settling |
| refInternal | output | 1 | Internal reference selected |
| refHigh | output | 1 | Internal reference at the higher voltage |

## Verification
A holding register with a wrong value stays hidden until the next load condition. It then appears on code one edge after loadN is seen low or the load bit is set, so the bench forces a load after each staged write. A wrong control bit shows on powerDown, fastSettle or the reference outputs on the edge after the control write. A wrong software load bit shows as code tracking, or failing to track, the next holding write. Write-edge errors (double writes, writes with select high, writes to the reserved address, the wrong bus sample) show as wrong code after the next load. A behavioural model is therefore compared on every clock, so a divergence is caught on its first cycle.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;
  localparam int CODE_W = 12;
  localparam int HI_W   = CODE_W - BUS_W;
  localparam int CTRL_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LO   = 2'b00,
    ADDR_HI   = 2'b01,
    ADDR_RSVD = 2'b10,
    ADDR_CTRL = 2'b11
  } addr_e;

  // Field order matches the bus bit positions 4..0
  typedef struct packed {
    logic refB;
    logic refA;
    logic loadBit;
    logic pwrBit;
    logic spdBit;
  } ctrl_t;

  typedef struct packed {
    logic             wrLo;
    logic             wrHi;
    logic             wrCtrl;
    logic [BUS_W-1:0] data;
  } wr_strobe_t;
endpackage

// File: rtl/dac_if_sync.sv
module dac_if_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/dac_if_ctrl.sv
module dac_if_ctrl
  import dac_if_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  busData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              selN,
  input  logic              wrN,
  input  logic              loadN,
  input  logic              pdPinN,
  input  logic              speedPin,
  output wr_strobe_t        stb,
  output logic              loadActive,
  output logic              pdReq,
  output logic              speedReq
);
  localparam int LVL_W = 4;
  localparam int BUSS_W = BUS_W + ADDR_W;

  logic [LVL_W-1:0]  lvlSync;
  logic [BUSS_W-1:0] busSync;
  logic              spdSync;
  logic              wrPrev;
  logic              selPrev;
  logic [BUSS_W-1:0] busPrev;
  logic              wrRise;
  addr_e             addrPrev;

  // Active-low levels idle high through reset
  dac_if_sync #(.W(LVL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_lvlSync (
    .clk(clk), .rstN(rstN),
    .din({selN, wrN, loadN, pdPinN}),
    .dout(lvlSync)
  );

  dac_if_sync #(.W(BUSS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_busSync (
    .clk(clk), .rstN(rstN),
    .din({busAddr, busData}),
    .dout(busSync)
  );

  dac_if_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_spdSync (
    .clk(clk), .rstN(rstN),
    .din(speedPin),
    .dout(spdSync)
  );

  // One extra sample for edge detection and bus capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev  <= 1'b1;
      selPrev <= 1'b1;
      busPrev <= '0;
    end else begin
      wrPrev  <= lvlSync[2];
      selPrev <= lvlSync[3];
      busPrev <= busSync;
    end
  end

  assign wrRise   = lvlSync[2] && !wrPrev && !selPrev;
  assign addrPrev = addr_e'(busPrev[BUSS_W-1:BUS_W]);

  always_comb begin
    stb      = '0;
    stb.data = busPrev[BUS_W-1:0];
    if (wrRise) begin
      unique case (addrPrev)
        ADDR_LO:   stb.wrLo   = 1'b1;
        ADDR_HI:   stb.wrHi   = 1'b1;
        ADDR_CTRL: stb.wrCtrl = 1'b1;
        default:   ;
      endcase
    end
  end

  assign loadActive = !lvlSync[1];
  assign pdReq      = !lvlSync[0];
  assign speedReq   = spdSync;

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrLo || stb.wrHi || stb.wrCtrl) |=> !(stb.wrLo || stb.wrHi || stb.wrCtrl));
endmodule

// File: rtl/dac_if_datapath.sv
module dac_if_datapath
  import dac_if_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wr_strobe_t        stb,
  input  logic              loadActive,
  input  logic              pdReq,
  input  logic              speedReq,
  output logic [CODE_W-1:0] code,
  output logic              powerDown,
  output logic              fastSettle,
  output logic              refInternal,
  output logic              refHigh
);
  logic [BUS_W-1:0]  loHold;
  logic [HI_W-1:0]   hiHold;
  ctrl_t             ctrlReg;
  logic [CODE_W-1:0] dacReg;
  logic              transparent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loHold  <= '0;
      hiHold  <= '0;
      ctrlReg <= '0;
    end else begin
      if (stb.wrLo)   loHold  <= stb.data;
      if (stb.wrHi)   hiHold  <= stb.data[HI_W-1:0];
      if (stb.wrCtrl) ctrlReg <= ctrl_t'(stb.data[CTRL_W-1:0]);
    end
  end

  assign transparent = loadActive || ctrlReg.loadBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dacReg <= '0;
    else if (transparent) dacReg <= {hiHold, loHold};
  end

  assign code        = dacReg;
  assign powerDown   = pdReq || ctrlReg.pwrBit;
  assign fastSettle  = speedReq || ctrlReg.spdBit;
  assign refInternal = ctrlReg.refB ^ ctrlReg.refA;
  assign refHigh     = ctrlReg.refB && !ctrlReg.refA;

  // R4
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrLo || stb.wrHi || stb.wrCtrl) |=> $stable({loHold, hiHold, ctrlReg}));
  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadActive && !ctrlReg.loadBit) |=> $stable(code));
  // R6
  latch_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadActive || ctrlReg.loadBit) |=> (code == $past({hiHold, loHold})));
  // R8
  pd_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    pdReq |-> powerDown);
  // R9
  fast_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    speedReq |-> fastSettle);
  // R10
  ref_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    refHigh |-> refInternal);
endmodule

// File: rtl/dac_byte_if.sv
module dac_byte_if
  import dac_if_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  busData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              selN,
  input  logic              wrN,
  input  logic              loadN,
  input  logic              pdPinN,
  input  logic              speedPin,
  output logic [CODE_W-1:0] code,
  output logic              powerDown,
  output logic              fastSettle,
  output logic              refInternal,
  output logic              refHigh
);
  wr_strobe_t stb;
  logic       loadActive;
  logic       pdReq;
  logic       speedReq;

  dac_if_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busData(busData), .busAddr(busAddr),
    .selN(selN), .wrN(wrN), .loadN(loadN),
    .pdPinN(pdPinN), .speedPin(speedPin),
    .stb(stb), .loadActive(loadActive),
    .pdReq(pdReq), .speedReq(speedReq)
  );

  dac_if_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .stb(stb), .loadActive(loadActive),
    .pdReq(pdReq), .speedReq(speedReq),
    .code(code), .powerDown(powerDown), .fastSettle(fastSettle),
    .refInternal(refInternal), .refHigh(refHigh)
  );
endmodule

// File: tb/tb_dac_byte_if.sv
module tb_dac_byte_if;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busData = '0;
  logic [1:0]  busAddr = '0;
  logic        selN = 1'b1, wrN = 1'b1, loadN = 1'b1, pdPinN = 1'b1, speedPin = 1'b0;
  logic [11:0] code;
  logic        powerDown, fastSettle, refInternal, refHigh;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  dac_byte_if dut (
    .clk(clk), .rstN(rstN), .busData(busData), .busAddr(busAddr),
    .selN(selN), .wrN(wrN), .loadN(loadN), .pdPinN(pdPinN), .speedPin(speedPin),
    .code(code), .powerDown(powerDown), .fastSettle(fastSettle),
    .refInternal(refInternal), .refHigh(refHigh)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model: input history, index 0 = most recent edge
  logic        hWr [4], hSel [4], hLd [4], hPd [4], hSpd [4];
  logic [1:0]  hAddr [4];
  logic [7:0]  hData [4];
  logic [7:0]  mLo = '0;
  logic [3:0]  mHi = '0;
  logic [4:0]  mCtrl = '0;
  logic [11:0] mDac = '0;

  task automatic idleHistory();
    for (int i = 0; i < 4; i++) begin
      hWr[i] = 1'b1; hSel[i] = 1'b1; hLd[i] = 1'b1; hPd[i] = 1'b1; hSpd[i] = 1'b0;
      hAddr[i] = '0; hData[i] = '0;
    end
  endtask

  initial idleHistory();

  always @(posedge clk) begin
    if (!rstN) begin
      idleHistory();
      mLo = '0; mHi = '0; mCtrl = '0; mDac = '0;
    end else begin
      // DAC register: load level seen two edges back, or software load bit
      if (!hLd[1] || mCtrl[2]) mDac = {mHi, mLo};
      // Write: rising strobe, select low in the prior sample, bus from prior sample
      if (hWr[1] && !hWr[2] && !hSel[2]) begin
        case (hAddr[2])
          2'd0: mLo = hData[2];
          2'd1: mHi = hData[2][3:0];
          2'd3: mCtrl = hData[2][4:0];
          default: ;
        endcase
      end
      for (int i = 3; i > 0; i--) begin
        hWr[i] = hWr[i-1]; hSel[i] = hSel[i-1]; hLd[i] = hLd[i-1];
        hPd[i] = hPd[i-1]; hSpd[i] = hSpd[i-1]; hAddr[i] = hAddr[i-1]; hData[i] = hData[i-1];
      end
      hWr[0] = wrN; hSel[0] = selN; hLd[0] = loadN; hPd[0] = pdPinN; hSpd[0] = speedPin;
      hAddr[0] = busAddr; hData[0] = busData;
    end
  end

  function automatic logic modelPd();
    return !hPd[1] || mCtrl[1];
  endfunction
  function automatic logic modelFast();
    return hSpd[1] || mCtrl[0];
  endfunction
  function automatic logic modelRefInt();
    return (mCtrl[4:3] == 2'b01) || (mCtrl[4:3] == 2'b10);
  endfunction
  function automatic logic modelRefHi();
    return mCtrl[4:3] == 2'b10;
  endfunction

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (code !== mDac) begin
        miscompares++;
        $display("FAIL R6 code actual=%0h expected=%0h", code, mDac);
      end
      if (powerDown !== modelPd()) begin
        miscompares++;
        $display("FAIL R8 powerDown actual=%0b expected=%0b", powerDown, modelPd());
      end
      if (fastSettle !== modelFast()) begin
        miscompares++;
        $display("FAIL R9 fastSettle actual=%0b expected=%0b", fastSettle, modelFast());
      end
      if ({refInternal, refHigh} !== {modelRefInt(), modelRefHi()}) begin
        miscompares++;
        $display("FAIL R10 ref actual=%0b%0b expected=%0b%0b",
                 refInternal, refHigh, modelRefInt(), modelRefHi());
      end
    end
  end

  task automatic checkVal(input string tag, input logic [11:0] act, input logic [11:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeByte(input logic [1:0] addr, input logic [7:0] data, input bit csActive);
    @(negedge clk);
    busAddr = addr; busData = data; selN = !csActive; wrN = 1'b0;
    waitClk(3);
    wrN = 1'b1;
    waitClk(3);
    selN = 1'b1;
    waitClk(2);
  endtask

  task automatic pulseLoad();
    @(negedge clk);
    loadN = 1'b0;
    waitClk(2);
    loadN = 1'b1;
    waitClk(4);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish();
    end
  end

  initial begin
    waitClk(4);
    // R1: reset state
    checkVal("R1 code", code, 12'h000);
    checkVal("R1 flags", {8'h0, powerDown, fastSettle, refInternal, refHigh}, 12'h000);
    @(negedge clk) rstN = 1'b1;
    waitClk(3);
    checkVal("R1 after release", code, 12'h000);

    // R3: staged low and high bytes, upper nibble of high byte ignored; R6 holds
    writeByte(2'b00, 8'h34, 1'b1);
    writeByte(2'b01, 8'hF5, 1'b1);
    checkVal("R6 hold without load", code, 12'h000);
    pulseLoad();
    checkVal("R3 staged code", code, 12'h534);

    // R4: reserved address changes nothing
    writeByte(2'b10, 8'hFF, 1'b1);
    checkVal("R4 flags", {8'h0, powerDown, fastSettle, refInternal, refHigh}, 12'h000);
    pulseLoad();
    checkVal("R4 code", code, 12'h534);

    // R12: select high blocks the write
    writeByte(2'b00, 8'h99, 1'b0);
    pulseLoad();
    checkVal("R12 ignored write", code, 12'h534);

    // R5 / R6: software load bit makes the DAC register follow
    writeByte(2'b11, 8'h04, 1'b1);
    writeByte(2'b00, 8'hAB, 1'b1);
    checkVal("R5 load bit follow", code, 12'h5AB);

    // R7: load pin held low, software load bit cleared
    @(negedge clk) loadN = 1'b0;
    writeByte(2'b11, 8'h00, 1'b1);
    writeByte(2'b01, 8'h0C, 1'b1);
    checkVal("R7 load held low", code, 12'hCAB);
    @(negedge clk) loadN = 1'b1;
    waitClk(3);

    // R8 / R11: software power-down and release keep the code
    writeByte(2'b11, 8'h02, 1'b1);
    checkVal("R8 pwr bit", {11'h0, powerDown}, 12'h001);
    checkVal("R11 code in power-down", code, 12'hCAB);
    writeByte(2'b11, 8'h00, 1'b1);
    checkVal("R8 pwr release", {11'h0, powerDown}, 12'h000);
    checkVal("R11 code after release", code, 12'hCAB);

    // R8: pin power-down
    @(negedge clk) pdPinN = 1'b0;
    waitClk(3);
    checkVal("R8 pin down", {11'h0, powerDown}, 12'h001);
    @(negedge clk) pdPinN = 1'b1;
    waitClk(3);
    checkVal("R8 pin up", {11'h0, powerDown}, 12'h000);
    checkVal("R11 code after pin", code, 12'hCAB);

    // R9: pin and bit select fast settling
    @(negedge clk) speedPin = 1'b1;
    waitClk(3);
    checkVal("R9 pin fast", {11'h0, fastSettle}, 12'h001);
    @(negedge clk) speedPin = 1'b0;
    waitClk(3);
    checkVal("R9 slow", {11'h0, fastSettle}, 12'h000);
    writeByte(2'b11, 8'h01, 1'b1);
    checkVal("R9 bit fast", {11'h0, fastSettle}, 12'h001);

    // R10: reference decode
    writeByte(2'b11, 8'h08, 1'b1);
    checkVal("R10 internal low", {10'h0, refInternal, refHigh}, 12'h002);
    writeByte(2'b11, 8'h10, 1'b1);
    checkVal("R10 internal high", {10'h0, refInternal, refHigh}, 12'h003);
    writeByte(2'b11, 8'h18, 1'b1);
    checkVal("R10 external", {10'h0, refInternal, refHigh}, 12'h000);

    // R2: back-to-back writes, last bus sample before the rise is taken
    @(negedge clk);
    busAddr = 2'b00; busData = 8'h11; selN = 1'b0; wrN = 1'b0;
    waitClk(2);
    busData = 8'h5E;
    waitClk(1);
    wrN = 1'b1;
    waitClk(3);
    selN = 1'b1;
    waitClk(2);
    pulseLoad();
    checkVal("R2 bus sample", code, 12'hC5E);

    waitClk(4);
    finish();
  end
endmodule